// File: doc/BRIEF.md
# Push-Button Duty Level Selector

This block keeps a 4-bit duty level with sixteen steps, from 0 to 15. A user moves the level up or down with two push-button inputs. The buttons arrive already synchronized to the clock. A new press moves the level by exactly one step on the first clock edge that samples the button high. If the button stays held, the level keeps stepping at a fixed auto-repeat period. The level stops at 0 and at 15 and does not wrap around.

A test-mode switch shortens the auto-repeat period by a factor of ten, so a held button sweeps the range quickly. The current level is driven onto a four-wire LED bus and onto a level bus that feeds a separate PWM generator. An active-low asynchronous reset clears the level to 0. The buttons, the mode switch and both outputs are plain control signals, with no handshake.

Top module: `duty_level_sel`

## Requirements
- R1: While `rst_n` is low, `level_o` is 0. Reset takes effect at once, without waiting for a clock edge.
- R2: When `btn_up` goes from low to high while `btn_dn` is low, `level_o` rises by one on the clock edge that first samples `btn_up` high.
- R3: When `btn_dn` goes from low to high while `btn_up` is low, `level_o` falls by one on the clock edge that first samples `btn_dn` high.
- R4: A step up at level 15 leaves the level at 15.
- R5: A step down at level 0 leaves the level at 0.
- R6: With `test_mode` low, a button held for N clock edges produces 1 + floor((N-1)/RPT_CYC) steps. RPT_CYC defaults to 50.
- R7: With `test_mode` high, a button held for N clock edges produces 1 + floor((N-1)/(RPT_CYC/10)) steps. With the default RPT_CYC this divisor is 5.
- R8: In any cycle where `btn_up` and `btn_dn` are both high, the level does not change.
- R9: `led_o` always carries the same value as `level_o`. Bit 0 of each bus is the least significant bit of the level.
- R10: The level never changes by more than one step between two consecutive clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_up | input | 1 | Raise button, already synchronized |
| btn_dn | input | 1 | Lower button, already synchronized |
| test_mode | input | 1 | High selects the auto-repeat period divided by ten |
| led_o | output | 4 | LED copy of the current level |
| level_o | output | 4 | Current level, sent to the PWM generator |

## Verification
The hardest behaviour to reach from the ports is the auto-repeat boundary. The first repeat step must come exactly RPT_CYC edges after the press, and a press held one edge less must give no repeat step. Saturation during a long held sweep is just as hard to reach.

The stimulus table holds each button for counts chosen on both sides of the repeat period, in both modes. Some long holds drive the level into 15 and into 0, so that the steps beyond each end must be absorbed.

// File: rtl/dls_pkg.sv
package dls_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;

  localparam int BTN_N  = 2;
  localparam int IDX_UP = 0;
  localparam int IDX_DN = 1;

endpackage

// File: rtl/dls_press_unit.sv
module dls_press_unit #(
  parameter int TERM_NORM = 50,
  parameter int TERM_TEST = 5,
  parameter int CNT_W     = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn,
  input  logic test_mode,
  output logic fire
);

  localparam logic [CNT_W-1:0] LIM_NORM = CNT_W'(TERM_NORM - 1);
  localparam logic [CNT_W-1:0] LIM_TEST = CNT_W'(TERM_TEST - 1);

  logic             btn_q;
  logic [CNT_W-1:0] hold_cnt;
  logic [CNT_W-1:0] limit;
  logic             rise;
  logic             wrap;

  assign limit = test_mode ? LIM_TEST : LIM_NORM;
  assign rise  = btn & ~btn_q;
  // The >= compare keeps the count bounded when the mode switches during a hold.
  assign wrap  = btn & btn_q & (hold_cnt >= limit);
  assign fire  = rise | wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btn_q    <= 1'b0;
      hold_cnt <= '0;
    end else begin
      btn_q <= btn;
      if (!btn || rise || wrap) begin
        hold_cnt <= '0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dls_step_arb.sv
module dls_step_arb
  import dls_pkg::*;
(
  input  logic [BTN_N-1:0] btn_lvl,
  input  logic [BTN_N-1:0] fire,
  output step_e            step
);

  always_comb begin
    step = STEP_NONE;
    if (btn_lvl[IDX_UP] && btn_lvl[IDX_DN]) begin
      step = STEP_NONE;
    end else if (fire[IDX_UP]) begin
      step = STEP_UP;
    end else if (fire[IDX_DN]) begin
      step = STEP_DN;
    end
  end

endmodule

// File: rtl/dls_level_reg.sv
module dls_level_reg
  import dls_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_e            step,
  output logic [LVL_W-1:0] level
);

  localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};
  localparam logic [LVL_W-1:0] LVL_MIN = '0;

  logic [LVL_W-1:0] level_nxt;

  always_comb begin
    level_nxt = level;
    unique case (step)
      STEP_UP: if (level != LVL_MAX) level_nxt = level + 1'b1;
      STEP_DN: if (level != LVL_MIN) level_nxt = level - 1'b1;
      default: level_nxt = level;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= LVL_MIN;
    end else begin
      level <= level_nxt;
    end
  end

endmodule

// File: rtl/duty_level_sel.sv
module duty_level_sel
  import dls_pkg::*;
#(
  parameter int LVL_W    = 4,
  parameter int RPT_CYC  = 50,
  parameter int TEST_DIV = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_up,
  input  logic             btn_dn,
  input  logic             test_mode,
  output logic [LVL_W-1:0] led_o,
  output logic [LVL_W-1:0] level_o
);

  localparam int TERM_TEST = (RPT_CYC / TEST_DIV) < 1 ? 1 : (RPT_CYC / TEST_DIV);
  localparam int CNT_W     = (RPT_CYC < 2) ? 1 : $clog2(RPT_CYC);

  logic [BTN_N-1:0] btn_vec;
  logic [BTN_N-1:0] fire_vec;
  step_e            step;
  logic [LVL_W-1:0] level_q;

  assign btn_vec[IDX_UP] = btn_up;
  assign btn_vec[IDX_DN] = btn_dn;

  for (genvar g = 0; g < BTN_N; g++) begin : g_press
    dls_press_unit #(
      .TERM_NORM (RPT_CYC),
      .TERM_TEST (TERM_TEST),
      .CNT_W     (CNT_W)
    ) u_press (
      .clk       (clk),
      .rst_n     (rst_n),
      .btn       (btn_vec[g]),
      .test_mode (test_mode),
      .fire      (fire_vec[g])
    );
  end

  dls_step_arb u_arb (
    .btn_lvl (btn_vec),
    .fire    (fire_vec),
    .step    (step)
  );

  dls_level_reg #(
    .LVL_W (LVL_W)
  ) u_level (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .level (level_q)
  );

  assign level_o = level_q;
  assign led_o   = level_q;

endmodule

// File: rtl/duty_level_sel_chk.sv
module duty_level_sel_chk #(
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             btn_up,
  input logic             btn_dn,
  input logic [LVL_W-1:0] level_o
);

  localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};

  // R1
  always_ff @(posedge clk) begin
    if (rst_n === 1'b0) begin
      in_reset_zero_chk: assert (level_o == '0);
    end
  end

  // R2
  up_press_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(btn_up) && !btn_dn && level_o != TOP) |=> (level_o == $past(level_o) + 1'b1));

  // R4
  top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o == TOP && btn_up && !btn_dn) |=> (level_o == TOP));

  // R5
  bottom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o == '0 && btn_dn && !btn_up) |=> (level_o == '0));

  // R8
  both_pressed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_up && btn_dn) |=> $stable(level_o));

  // R10
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (level_o == $past(level_o) || level_o == $past(level_o) + 1'b1
              || level_o == $past(level_o) - 1'b1));

endmodule

bind duty_level_sel duty_level_sel_chk #(.LVL_W(LVL_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .btn_up  (btn_up),
  .btn_dn  (btn_dn),
  .level_o (level_o)
);

// File: tb/duty_level_sel_bench.sv
module duty_level_sel_bench;

  typedef struct packed {
    logic        up;
    logic        dn;
    logic        tm;
    logic [15:0] hold;
    logic [3:0]  expect_lvl;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 1'b0, 1'b0, 16'd1,   4'd1,  4'd2},  // R2 single press
    '{1'b1, 1'b0, 1'b0, 16'd1,   4'd2,  4'd2},  // R2 second press
    '{1'b0, 1'b1, 1'b0, 16'd1,   4'd1,  4'd3},  // R3 single press down
    '{1'b1, 1'b0, 1'b0, 16'd50,  4'd2,  4'd6},  // R6 one edge short of a repeat
    '{1'b1, 1'b0, 1'b0, 16'd51,  4'd4,  4'd6},  // R6 first repeat lands
    '{1'b1, 1'b0, 1'b1, 16'd11,  4'd7,  4'd7},  // R7 fast repeat, two extra steps
    '{1'b1, 1'b1, 1'b0, 16'd20,  4'd7,  4'd8},  // R8 both held
    '{1'b0, 1'b1, 1'b1, 16'd6,   4'd5,  4'd7},  // R7 fast repeat down
    '{1'b1, 1'b0, 1'b1, 16'd60,  4'd15, 4'd4},  // R4 sweep into the top
    '{1'b0, 1'b1, 1'b0, 16'd101, 4'd12, 4'd6},  // R6 two repeats down
    '{1'b0, 1'b1, 1'b1, 16'd100, 4'd0,  4'd5},  // R5 sweep into the bottom
    '{1'b0, 1'b1, 1'b0, 16'd1,   4'd0,  4'd5},  // R5 press at zero
    '{1'b1, 1'b0, 1'b0, 16'd1,   4'd1,  4'd2}   // R2 up from zero
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       btn_up = 1'b0;
  logic       btn_dn = 1'b0;
  logic       test_mode = 1'b0;
  logic [3:0] led_o;
  logic [3:0] level_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  duty_level_sel u_duty_level_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .btn_up    (btn_up),
    .btn_dn    (btn_dn),
    .test_mode (test_mode),
    .led_o     (led_o),
    .level_o   (level_o)
  );

  task automatic check(input int req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic press(input logic u, input logic d, input logic tm, input int n);
    @(negedge clk);
    btn_up = u;
    btn_dn = d;
    test_mode = tm;
    repeat (n) @(posedge clk);
    @(negedge clk);
    btn_up = 1'b0;
    btn_dn = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1, level_o, 4'd0);  // R1 level held at zero during reset
    rst_n = 1'b1;
    @(negedge clk);
    check(1, level_o, 4'd0);  // R1 reset value
    check(9, led_o, 4'd0);    // R9

    for (int i = 0; i < NVEC; i++) begin
      press(VEC[i].up, VEC[i].dn, VEC[i].tm, int'(VEC[i].hold));
      check(int'(VEC[i].req), level_o, VEC[i].expect_lvl);
      check(9, led_o, VEC[i].expect_lvl);  // R9 LED mirror
    end

    // R1: an asynchronous reset mid-cycle clears the level before any edge.
    press(1'b1, 1'b0, 1'b0, 1);
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1 check(1, level_o, 4'd0);
    check(9, led_o, 4'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: a press down at level 1 takes the level back to 0.
    press(1'b1, 1'b0, 1'b0, 1);
    press(1'b0, 1'b1, 1'b0, 1);
    check(3, level_o, 4'd0);

    // R8: both buttons rising together from idle give no step.
    press(1'b1, 1'b1, 1'b1, 7);
    check(8, level_o, 4'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule